// File: doc/BRIEF.md
# Two-Entry Tag-Matching Reservation Station

This block sits in front of one functional unit in a machine that schedules instructions dynamically and shares results by tag broadcast. Two station entries are wired into it, each with a fixed station tag set by a parameter. A dispatch stage drives up to two instruction buses in each cycle. An entry whose tag appears in the destination-station field of a valid instruction takes in that instruction's function code and two source tags. Each source is either marked available with its value, or left pending on a producer tag.

While a source is pending, the entry compares the source's tag against the tags on all five result buses in every cycle. It copies the value when a valid bus carries that tag. No central sequencer exists: each entry decides on its own when it is loaded, when it has both operands and when it may be released. A small picker sends at most one complete entry per cycle into a single-cycle arithmetic stage. The stage drives the result, labelled with the entry's station tag, onto the one result bus the unit owns. Dispatch sees a busy flag for each entry, so it only targets free stations.

Top module: `tag_station_unit`

## Requirements
- R1: During and right after reset, both busy flags are low and the owned result bus is not valid.
- R2: A free entry is loaded at the clock edge in which a valid instruction bus carries that entry's station tag in its station field. Its busy flag is high from the next cycle. If both instruction buses target the unit, the two entries may be loaded in the same cycle.
- R3: A source flagged available on the instruction bus takes its value from that bus. A pending source whose tag is on a valid result bus in the dispatch cycle itself is also captured at once.
- R4: A loaded entry compares each pending source tag against all five result buses in every cycle. It captures the data from a valid bus whose tag matches. Buses with other tags leave the entry unchanged, and the two sources may arrive on different buses and in different cycles.
- R5: An entry is launched only once both sources are held. Its result is valid on the owned bus in the next cycle and carries the entry's station tag. The function codes are 0 = sum, 1 = bitwise NOR, 2 = first operand shifted left by the low log2(DATA_W) bits of the second, and 3 = logical right shift by the same amount.
- R6: At most one entry launches per cycle. When both entries are complete together, the one loaded earlier goes first and the other goes in the following cycle. Of two entries loaded in the same cycle, the one loaded from the lower-numbered instruction bus counts as older.
- R7: An entry's busy flag stays high during its broadcast cycle and drops in the cycle after, when the entry can be loaded again.
- R8: An instruction aimed at an entry that is still busy is ignored. The entry keeps its function, tags and operands, and its later result is the one from the original instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ib_valid | input | N_IB | Instruction bus valid, one bit per bus |
| ib_station | input | N_IB*TAG_W | Destination station tag per instruction bus |
| ib_func | input | N_IB*2 | Function code per instruction bus |
| ib_a_tag | input | N_IB*TAG_W | First source producer tag |
| ib_a_rdy | input | N_IB | First source value already available |
| ib_a_val | input | N_IB*DATA_W | First source value when available |
| ib_b_tag | input | N_IB*TAG_W | Second source producer tag |
| ib_b_rdy | input | N_IB | Second source value already available |
| ib_b_val | input | N_IB*DATA_W | Second source value when available |
| db_valid | input | N_DB | Result bus valid, one bit per bus |
| db_tag | input | N_DB*TAG_W | Result bus producer tag |
| db_data | input | N_DB*DATA_W | Result bus data |
| res_valid | output | 1 | Owned result bus valid |
| res_tag | output | TAG_W | Station tag of the broadcast result |
| res_data | output | DATA_W | Broadcast result value |
| stn_busy | output | 2 | Busy flag per entry (bit 0 = entry with STN_TAG0) |

## Verification
The assertions check in every cycle that a launch only happens for an entry that holds both operands and has not been launched yet, and that at most one launch happens per cycle. They also check that the older entry wins a tie, that a launch is always followed by a broadcast carrying one of the unit's own tags, and that an entry is released right after its broadcast. Two further checks hold an entry's tags, function and captured operands steady while it waits. Only the bench scenarios can show that the values are right. These cover snooping against foreign and matching tags on several buses, capture in the dispatch cycle, same-cycle allocation from both instruction buses, the launch order when two entries complete together, and the unchanged result after an instruction aimed at a busy station.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    localparam int FN_W = 2;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 2'd0,
        FN_NOR = 2'd1,
        FN_SLL = 2'd2,
        FN_SRL = 2'd3
    } fn_e;
endpackage

// File: rtl/tsu_entry.sv
module tsu_entry
    import tsu_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter int              TAG_W  = 4,
    parameter int              N_IB   = 2,
    parameter int              N_DB   = 5,
    parameter logic [TAG_W-1:0] MY_TAG = '0,
    localparam int             IW     = (N_IB > 1) ? $clog2(N_IB) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IB-1:0]        ib_valid,
    input  logic [N_IB*TAG_W-1:0]  ib_station,
    input  logic [N_IB*FN_W-1:0]   ib_func,
    input  logic [N_IB*TAG_W-1:0]  ib_a_tag,
    input  logic [N_IB-1:0]        ib_a_rdy,
    input  logic [N_IB*DATA_W-1:0] ib_a_val,
    input  logic [N_IB*TAG_W-1:0]  ib_b_tag,
    input  logic [N_IB-1:0]        ib_b_rdy,
    input  logic [N_IB*DATA_W-1:0] ib_b_val,
    input  logic [N_DB-1:0]        db_valid,
    input  logic [N_DB*TAG_W-1:0]  db_tag,
    input  logic [N_DB*DATA_W-1:0] db_data,
    input  logic                   launch_i,
    output logic                   busy_o,
    output logic                   ready_o,
    output logic                   alloc_o,
    output logic [IW-1:0]          alloc_bus_o,
    output logic [FN_W-1:0]        func_o,
    output logic [DATA_W-1:0]      a_o,
    output logic [DATA_W-1:0]      b_o
);
    typedef struct packed {
        logic              busy;
        logic              issued;
        fn_e               func;
        logic [TAG_W-1:0]  a_tag;
        logic [TAG_W-1:0]  b_tag;
        logic              a_v;
        logic              b_v;
        logic [DATA_W-1:0] a_val;
        logic [DATA_W-1:0] b_val;
    } ent_t;

    ent_t s_d, s_q;

    // Lowest-numbered matching result bus wins; returns {hit, data}.
    function automatic logic [DATA_W:0] snoop(input logic [TAG_W-1:0] t);
        logic [DATA_W:0] r;
        r = '0;
        for (int j = N_DB - 1; j >= 0; j--) begin
            if (db_valid[j] && db_tag[j*TAG_W +: TAG_W] == t)
                r = {1'b1, db_data[j*DATA_W +: DATA_W]};
        end
        return r;
    endfunction

    logic            hit_d;
    logic [IW-1:0]   hit_bus_d;
    logic [DATA_W:0] sa_d, sb_d;
    logic [TAG_W-1:0] a_tag_in, b_tag_in;

    always_comb begin
        hit_d     = 1'b0;
        hit_bus_d = '0;
        for (int k = N_IB - 1; k >= 0; k--) begin
            if (ib_valid[k] && ib_station[k*TAG_W +: TAG_W] == MY_TAG) begin
                hit_d     = 1'b1;
                hit_bus_d = IW'(k);
            end
        end

        a_tag_in = ib_a_tag[hit_bus_d*TAG_W +: TAG_W];
        b_tag_in = ib_b_tag[hit_bus_d*TAG_W +: TAG_W];
        sa_d     = snoop(s_q.busy ? s_q.a_tag : a_tag_in);
        sb_d     = snoop(s_q.busy ? s_q.b_tag : b_tag_in);

        s_d = s_q;
        if (!s_q.busy) begin
            if (hit_d) begin
                s_d.busy   = 1'b1;
                s_d.issued = 1'b0;
                s_d.func   = fn_e'(ib_func[hit_bus_d*FN_W +: FN_W]);
                s_d.a_tag  = a_tag_in;
                s_d.b_tag  = b_tag_in;
                if (ib_a_rdy[hit_bus_d]) begin
                    s_d.a_v   = 1'b1;
                    s_d.a_val = ib_a_val[hit_bus_d*DATA_W +: DATA_W];
                end else begin
                    s_d.a_v   = sa_d[DATA_W];
                    s_d.a_val = sa_d[DATA_W-1:0];
                end
                if (ib_b_rdy[hit_bus_d]) begin
                    s_d.b_v   = 1'b1;
                    s_d.b_val = ib_b_val[hit_bus_d*DATA_W +: DATA_W];
                end else begin
                    s_d.b_v   = sb_d[DATA_W];
                    s_d.b_val = sb_d[DATA_W-1:0];
                end
            end
        end else if (s_q.issued) begin
            s_d.busy   = 1'b0;
            s_d.issued = 1'b0;
            s_d.a_v    = 1'b0;
            s_d.b_v    = 1'b0;
        end else begin
            if (launch_i) s_d.issued = 1'b1;
            if (!s_q.a_v && sa_d[DATA_W]) begin
                s_d.a_v   = 1'b1;
                s_d.a_val = sa_d[DATA_W-1:0];
            end
            if (!s_q.b_v && sb_d[DATA_W]) begin
                s_d.b_v   = 1'b1;
                s_d.b_val = sb_d[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o      = s_q.busy;
    assign ready_o     = s_q.busy && !s_q.issued && s_q.a_v && s_q.b_v;
    assign alloc_o     = !s_q.busy && hit_d;
    assign alloc_bus_o = hit_bus_d;
    assign func_o      = s_q.func;
    assign a_o         = s_q.a_val;
    assign b_o         = s_q.b_val;

    // R5: the picker only launches a complete, not yet launched entry
    p_launch_complete_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> (s_q.busy && !s_q.issued && s_q.a_v && s_q.b_v));

    // R7: an entry is released right after its broadcast cycle
    p_release_after_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.issued) |=> !s_q.busy);

    // R8: a waiting entry keeps its instruction fields
    p_fields_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.issued) |=>
            ($stable(s_q.func) && $stable(s_q.a_tag) && $stable(s_q.b_tag)));

    // R4: a captured operand is never overwritten while waiting
    p_operand_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.issued && s_q.a_v && s_q.b_v) |=>
            ($stable(s_q.a_val) && $stable(s_q.b_val)));
endmodule

// File: rtl/tsu_pick.sv
module tsu_pick #(
    parameter int  N_IB = 2,
    localparam int IW   = (N_IB > 1) ? $clog2(N_IB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ready_i,
    input  logic [1:0]    busy_i,
    input  logic [1:0]    alloc_i,
    input  logic [2*IW-1:0] alloc_bus_i,
    output logic [1:0]    launch_o
);
    // older_q: index of the entry that was loaded first
    logic older_d, older_q;

    always_comb begin
        if (&ready_i) launch_o = older_q ? 2'b10 : 2'b01;
        else          launch_o = ready_i;

        older_d = older_q;
        case (alloc_i)
            2'b11:   older_d = (alloc_bus_i[IW +: IW] < alloc_bus_i[0 +: IW]);
            2'b01:   older_d = busy_i[1];
            2'b10:   older_d = !busy_i[0];
            default: older_d = older_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= 1'b0;
        else        older_q <= older_d;
    end

    // R6: never more than one launch per cycle
    p_single_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(launch_o));

    // R6: a tie goes to the older entry, the other follows next cycle
    p_tie_then_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&ready_i) |=> (launch_o == (older_q ? 2'b01 : 2'b10)));
endmodule

// File: rtl/tsu_exec.sv
module tsu_exec
    import tsu_pkg::*;
#(
    parameter int               DATA_W = 16,
    parameter int               TAG_W  = 4,
    parameter logic [TAG_W-1:0] TAG0   = '0,
    parameter logic [TAG_W-1:0] TAG1   = '1,
    localparam int              SH_W   = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          launch_i,
    input  logic [2*FN_W-1:0]   func_i,
    input  logic [2*DATA_W-1:0] a_i,
    input  logic [2*DATA_W-1:0] b_i,
    output logic                res_valid,
    output logic [TAG_W-1:0]    res_tag,
    output logic [DATA_W-1:0]   res_data
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } bcast_t;

    bcast_t out_d, out_q;
    logic              sel;
    fn_e               fn;
    logic [DATA_W-1:0] a, b;

    always_comb begin
        sel = launch_i[1];
        fn  = fn_e'(sel ? func_i[FN_W +: FN_W] : func_i[0 +: FN_W]);
        a   = sel ? a_i[DATA_W +: DATA_W] : a_i[0 +: DATA_W];
        b   = sel ? b_i[DATA_W +: DATA_W] : b_i[0 +: DATA_W];

        out_d.valid = |launch_i;
        out_d.tag   = sel ? TAG1 : TAG0;
        case (fn)
            FN_ADD:  out_d.data = a + b;
            FN_NOR:  out_d.data = ~(a | b);
            FN_SLL:  out_d.data = a << b[SH_W-1:0];
            default: out_d.data = a >> b[SH_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_valid = out_q.valid;
    assign res_tag   = out_q.tag;
    assign res_data  = out_q.data;

    // R5: every launch produces a broadcast in the next cycle, and only then
    p_launch_to_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|launch_i) |=> res_valid);
    p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|launch_i) |=> !res_valid);

    // R5: a broadcast always carries one of this unit's station tags
    p_own_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_tag == TAG0 || res_tag == TAG1));
endmodule

// File: rtl/tag_station_unit.sv
module tag_station_unit
    import tsu_pkg::*;
#(
    parameter int               DATA_W   = 16,
    parameter int               TAG_W    = 4,
    parameter int               N_IB     = 2,
    parameter int               N_DB     = 5,
    parameter logic [TAG_W-1:0] STN_TAG0 = 4'd4,
    parameter logic [TAG_W-1:0] STN_TAG1 = 4'd5,
    localparam int              IW       = (N_IB > 1) ? $clog2(N_IB) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IB-1:0]        ib_valid,
    input  logic [N_IB*TAG_W-1:0]  ib_station,
    input  logic [N_IB*FN_W-1:0]   ib_func,
    input  logic [N_IB*TAG_W-1:0]  ib_a_tag,
    input  logic [N_IB-1:0]        ib_a_rdy,
    input  logic [N_IB*DATA_W-1:0] ib_a_val,
    input  logic [N_IB*TAG_W-1:0]  ib_b_tag,
    input  logic [N_IB-1:0]        ib_b_rdy,
    input  logic [N_IB*DATA_W-1:0] ib_b_val,
    input  logic [N_DB-1:0]        db_valid,
    input  logic [N_DB*TAG_W-1:0]  db_tag,
    input  logic [N_DB*DATA_W-1:0] db_data,
    output logic                   res_valid,
    output logic [TAG_W-1:0]       res_tag,
    output logic [DATA_W-1:0]      res_data,
    output logic [1:0]             stn_busy
);
    logic [1:0]          busy_w, ready_w, alloc_w, launch_w;
    logic [2*IW-1:0]     alloc_bus_w;
    logic [2*FN_W-1:0]   func_w;
    logic [2*DATA_W-1:0] a_w, b_w;

    for (genvar e = 0; e < 2; e++) begin : g_ent
        tsu_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .N_IB   (N_IB),
            .N_DB   (N_DB),
            .MY_TAG ((e == 0) ? STN_TAG0 : STN_TAG1)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .ib_valid    (ib_valid),
            .ib_station  (ib_station),
            .ib_func     (ib_func),
            .ib_a_tag    (ib_a_tag),
            .ib_a_rdy    (ib_a_rdy),
            .ib_a_val    (ib_a_val),
            .ib_b_tag    (ib_b_tag),
            .ib_b_rdy    (ib_b_rdy),
            .ib_b_val    (ib_b_val),
            .db_valid    (db_valid),
            .db_tag      (db_tag),
            .db_data     (db_data),
            .launch_i    (launch_w[e]),
            .busy_o      (busy_w[e]),
            .ready_o     (ready_w[e]),
            .alloc_o     (alloc_w[e]),
            .alloc_bus_o (alloc_bus_w[e*IW +: IW]),
            .func_o      (func_w[e*FN_W +: FN_W]),
            .a_o         (a_w[e*DATA_W +: DATA_W]),
            .b_o         (b_w[e*DATA_W +: DATA_W])
        );
    end

    tsu_pick #(.N_IB(N_IB)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready_w),
        .busy_i      (busy_w),
        .alloc_i     (alloc_w),
        .alloc_bus_i (alloc_bus_w),
        .launch_o    (launch_w)
    );

    tsu_exec #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .TAG0   (STN_TAG0),
        .TAG1   (STN_TAG1)
    ) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch_w),
        .func_i    (func_w),
        .a_i       (a_w),
        .b_i       (b_w),
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .res_data  (res_data)
    );

    assign stn_busy = busy_w;

    // R1: nothing is broadcast unless some entry is occupied
    p_bcast_needs_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (|busy_w));
endmodule

// File: tb/tag_station_unit_test.sv
`timescale 1ns/1ps
module tag_station_unit_test;
    localparam int DW = 16;
    localparam int TW = 4;
    localparam int NI = 2;
    localparam int ND = 5;
    localparam logic [TW-1:0] S0 = 4'd4;
    localparam logic [TW-1:0] S1 = 4'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0]    ib_valid;
    logic [NI*TW-1:0] ib_station, ib_a_tag, ib_b_tag;
    logic [NI*2-1:0]  ib_func;
    logic [NI-1:0]    ib_a_rdy, ib_b_rdy;
    logic [NI*DW-1:0] ib_a_val, ib_b_val;
    logic [ND-1:0]    db_valid;
    logic [ND*TW-1:0] db_tag;
    logic [ND*DW-1:0] db_data;
    logic             res_valid;
    logic [TW-1:0]    res_tag;
    logic [DW-1:0]    res_data;
    logic [1:0]       stn_busy;

    tag_station_unit #(.DATA_W(DW), .TAG_W(TW), .N_IB(NI), .N_DB(ND),
                       .STN_TAG0(S0), .STN_TAG1(S1)) uut (
        .clk(clk), .rst_n(rst_n),
        .ib_valid(ib_valid), .ib_station(ib_station), .ib_func(ib_func),
        .ib_a_tag(ib_a_tag), .ib_a_rdy(ib_a_rdy), .ib_a_val(ib_a_val),
        .ib_b_tag(ib_b_tag), .ib_b_rdy(ib_b_rdy), .ib_b_val(ib_b_val),
        .db_valid(db_valid), .db_tag(db_tag), .db_data(db_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .stn_busy(stn_busy)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
        string         req;
    } item_t;

    item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [DW-1:0] model(input logic [1:0] fn,
                                            input logic [DW-1:0] a, b);
        case (fn)
            2'd0:    return a + b;
            2'd1:    return ~(a | b);
            2'd2:    return a << b[3:0];
            default: return a >> b[3:0];
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_res(input logic [TW-1:0] tag, input logic [DW-1:0] data,
                              input string req);
        item_t it;
        it.tag = tag; it.data = data; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic dispatch(input int bus, input logic [TW-1:0] stn,
                            input logic [1:0] fn,
                            input logic [TW-1:0] at, input logic ar, input logic [DW-1:0] av,
                            input logic [TW-1:0] bt, input logic br, input logic [DW-1:0] bv);
        ib_valid[bus]             = 1'b1;
        ib_station[bus*TW +: TW]  = stn;
        ib_func[bus*2 +: 2]       = fn;
        ib_a_tag[bus*TW +: TW]    = at;
        ib_a_rdy[bus]             = ar;
        ib_a_val[bus*DW +: DW]    = av;
        ib_b_tag[bus*TW +: TW]    = bt;
        ib_b_rdy[bus]             = br;
        ib_b_val[bus*DW +: DW]    = bv;
    endtask

    task automatic drive_db(input int j, input logic [TW-1:0] t, input logic [DW-1:0] d);
        db_valid[j]            = 1'b1;
        db_tag[j*TW +: TW]     = t;
        db_data[j*DW +: DW]    = d;
    endtask

    task automatic step();
        @(negedge clk);
        ib_valid = '0;
        db_valid = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: every broadcast must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid && !done) begin
            if (sb_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL unexpected broadcast (R5/R8): actual tag %0h data %0h expected none",
                         res_tag, res_data);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk({it.req, " tag"}, 32'(res_tag), 32'(it.tag));
                chk({it.req, " data"}, 32'(res_data), 32'(it.data));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
    end

    initial begin
        ib_valid = '0; ib_station = '0; ib_func = '0;
        ib_a_tag = '0; ib_a_rdy = '0; ib_a_val = '0;
        ib_b_tag = '0; ib_b_rdy = '0; ib_b_val = '0;
        db_valid = '0; db_tag = '0; db_data = '0;

        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(stn_busy), 32'd0);
        chk("R1 valid", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1 busy after release", 32'(stn_busy), 32'd0);

        // R2/R5/R7: both operands available at dispatch, sum
        dispatch(0, S0, 2'd0, 4'd0, 1'b1, 16'd3, 4'd0, 1'b1, 16'd4);
        expect_res(S0, model(2'd0, 16'd3, 16'd4), "R5 sum");
        step();
        chk("R2 busy after load", 32'(stn_busy), 32'b01);
        step();
        chk("R7 busy during broadcast", 32'(stn_busy), 32'b01);
        step();
        chk("R7 free after broadcast", 32'(stn_busy), 32'b00);
        idle(2);

        // R4: operands snooped on different buses; foreign tag ignored
        dispatch(1, S1, 2'd1, 4'd9, 1'b0, 16'd0, 4'd10, 1'b0, 16'd0);
        step();
        step();
        drive_db(1, 4'd7, 16'h1111);
        drive_db(3, 4'd9, 16'h00F0);
        step();
        chk("R4 waiting for second operand", 32'(stn_busy), 32'b10);
        drive_db(4, 4'd10, 16'h0F00);
        expect_res(S1, model(2'd1, 16'h00F0, 16'h0F00), "R4 snoop nor");
        step();
        idle(4);

        // R3: pending tag seen on a result bus in the dispatch cycle
        dispatch(0, S0, 2'd0, 4'd11, 1'b0, 16'd0, 4'd0, 1'b1, 16'd5);
        drive_db(2, 4'd11, 16'h0020);
        expect_res(S0, model(2'd0, 16'h0020, 16'd5), "R3 same-cycle capture");
        step();
        idle(4);

        // R6: both waiting on one tag, entry at S1 loaded first
        dispatch(1, S1, 2'd2, 4'd12, 1'b0, 16'd0, 4'd0, 1'b1, 16'd2);
        step();
        dispatch(0, S0, 2'd3, 4'd12, 1'b0, 16'd0, 4'd0, 1'b1, 16'd1);
        step();
        drive_db(0, 4'd12, 16'h0081);
        expect_res(S1, model(2'd2, 16'h0081, 16'd2), "R6 older first");
        expect_res(S0, model(2'd3, 16'h0081, 16'd1), "R6 younger next");
        step();
        idle(5);

        // R2/R6: same-cycle load from both buses; bus 0 entry is older
        dispatch(0, S1, 2'd0, 4'd13, 1'b0, 16'd0, 4'd0, 1'b1, 16'd1);
        dispatch(1, S0, 2'd1, 4'd13, 1'b0, 16'd0, 4'd0, 1'b1, 16'd0);
        step();
        chk("R2 both loaded together", 32'(stn_busy), 32'b11);
        drive_db(4, 4'd13, 16'h00FF);
        expect_res(S1, model(2'd0, 16'h00FF, 16'd1), "R6 lower bus older");
        expect_res(S0, model(2'd1, 16'h00FF, 16'd0), "R6 other follows");
        step();
        idle(5);

        // R8: instruction aimed at a busy entry is ignored
        dispatch(0, S0, 2'd0, 4'd14, 1'b0, 16'd0, 4'd0, 1'b1, 16'd1);
        step();
        dispatch(1, S0, 2'd1, 4'd0, 1'b1, 16'd5, 4'd0, 1'b1, 16'd5);
        step();
        step();
        chk("R8 still waiting", 32'(stn_busy), 32'b01);
        drive_db(1, 4'd14, 16'h0010);
        expect_res(S0, model(2'd0, 16'h0010, 16'd1), "R8 original kept");
        step();
        idle(5);

        // R5: shifts, loaded together, bus 0 entry first
        dispatch(0, S1, 2'd3, 4'd0, 1'b1, 16'h8000, 4'd0, 1'b1, 16'd15);
        dispatch(1, S0, 2'd2, 4'd0, 1'b1, 16'h0003, 4'd0, 1'b1, 16'h0011);
        expect_res(S1, model(2'd3, 16'h8000, 16'd15), "R5 right shift");
        expect_res(S0, model(2'd2, 16'h0003, 16'h0011), "R5 left shift");
        step();
        idle(6);

        chk("R5 all results seen", 32'(sb_q.size()), 32'd0);
        chk("R7 idle at end", 32'(stn_busy), 32'b00);
        done = 1'b1;
        summary();
    end
endmodule